// File: doc/BRIEF.md
# Multithreaded Issue Selector with Shared Complex-Unit Arbiter

This block is the issue front end of a cluster of small multithreaded expression cores. Each core runs four hardware thread contexts. In every cycle each core offers at most one operation. It picks the lowest-numbered context that has an operation ready and is not waiting on an earlier result. An operation goes to one of two places. The first is the core's private simple unit, which is pipelined and has a fixed latency. The second is a complex unit shared by all the cores of the cluster; it handles logarithm, division, exponential and float-to-integer conversion and also has a fixed latency.

A context that issues is marked stalled. The mark stays until its result comes back with that context's tag, so a long operation never blocks the other contexts of the same core. Requests for the shared complex unit are served one per cycle in round-robin order across the cores. A core that loses arbitration keeps the same context selected and retries on the next cycle. It issues nothing else in the meantime. Instruction decode and the arithmetic are not modelled: each unit is a tagged delay line.

Top module: `fxp_issue_cluster`

## Requirements
- R1: While reset is low, all state returns to idle. After reset no context is stalled, no issue or writeback is signalled, and the first complex-unit contention is won by core 0.
- R2: Each core issues at most one operation per cycle. It picks the lowest-indexed context whose `want` bit is set and whose stall bit is clear. `iss_cplx` shows the unit: 0 is simple, 1 is complex.
- R3: A context's stall bit (bit `c*4+t` of `stall_o`) is set after the cycle in which it issues. It stays set up to and including the cycle in which its result is written back. A stalled context is never selected.
- R4: An operation issued to the simple unit in cycle t is written back in cycle t+4 on `sp_wb_vld`/`sp_wb_tid` of its core. Its context can issue again from cycle t+5.
- R5: An operation granted the complex unit in cycle t is written back in cycle t+20 with its core and context tag on `cx_wb_*`. Its context can issue again from cycle t+21.
- R6: At most one core is granted the complex unit per cycle. The search starts at a pointer, and after a grant the pointer moves to the core that follows the granted one, wrapping from 5 to 0.
- R7: A core whose complex request is refused issues nothing in that cycle. On the next cycle it selects the same context again, even if a higher-priority context has become ready.
- R8: The simple unit accepts a new operation every cycle, so a core with four ready contexts issues in four consecutive cycles.
- R9: The complex unit accepts a new operation every cycle, so six requesting cores are granted in six consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| want | input | 24 | Bit c*4+t: context t of core c has an operation ready |
| cplx | input | 24 | Bit c*4+t: that operation needs the complex unit |
| iss_vld | output | 6 | Core c issues an operation this cycle |
| iss_tid | output | 12 | Issuing context of core c (bits c*2+:2) |
| iss_cplx | output | 6 | Issued operation goes to the complex unit |
| cx_gnt_vld | output | 1 | Complex unit granted this cycle |
| cx_gnt_core | output | 3 | Core granted the complex unit |
| sp_wb_vld | output | 6 | Simple-unit result returns for core c |
| sp_wb_tid | output | 12 | Context tag of that result (bits c*2+:2) |
| cx_wb_vld | output | 1 | Complex-unit result returns |
| cx_wb_core | output | 3 | Core tag of the complex result |
| cx_wb_tid | output | 2 | Context tag of the complex result |
| stall_o | output | 24 | Stall bit of each context |

## Verification
The assertions check, on every cycle, these properties: a stalled context is never issued; each writeback tag belongs to a stalled context; at most one complex grant is made, and only to a requester; the core after the last grant wins if it requests; a refused core retries the same context. The exact latencies of both units, the lowest-index choice among ready contexts, and the back-to-back throughput of each unit are shown only by the bench. Its behavioural model predicts every output in every cycle under directed and random traffic.

// File: rtl/fxp_pkg.sv
// Shared constants and helpers for the issue cluster.
// Assumes: nothing beyond IEEE 1800-2017.
package fxp_pkg;
    localparam int DEF_CORES      = 6;
    localparam int DEF_THREADS    = 4;
    localparam int DEF_SIMPLE_LAT = 4;
    localparam int DEF_CPLX_LAT   = 20;

    // Increment with wrap-around at n.
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/fxp_lat_pipe.sv
// Fixed-latency tagged delay line that stands in for a fully pipelined unit.
// An entry presented in cycle t appears at the output in cycle t+LAT.
// Assumes: LAT >= 2.
module fxp_lat_pipe #(
    parameter int LAT  = 4,
    parameter int TAGW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [TAGW-1:0] in_tag,
    output logic            out_vld,
    output logic [TAGW-1:0] out_tag
);
    logic [LAT-1:0]  v_q;
    logic [TAGW-1:0] tag_q [LAT];

    // Shift valid and tag one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int k = 0; k < LAT; k++) tag_q[k] <= '0;
        end else begin
            v_q      <= {v_q[LAT-2:0], in_vld};
            tag_q[0] <= in_tag;
            for (int k = 1; k < LAT; k++) tag_q[k] <= tag_q[k-1];
        end
    end

    assign out_vld = v_q[LAT-1];
    assign out_tag = tag_q[LAT-1];
endmodule

// File: rtl/fxp_rr_arb.sv
// Round-robin arbiter for the shared complex unit: one grant per cycle,
// search starts at a pointer that moves past the last granted requester.
// Assumes: requests are level signals evaluated in the same cycle.
module fxp_rr_arb #(
    parameter  int N  = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] after_idx;

    // Search requesters starting at the pointer, first hit wins.
    always_comb begin
        int idx;
        gnt     = '0;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = 0; off < N; off++) begin
            idx = int'(ptr_q) + off;
            if (idx >= N) idx = idx - N;
            if (!gnt_vld && req[idx]) begin
                gnt_vld      = 1'b1;
                gnt_idx      = IW'(idx);
                gnt[idx]     = 1'b1;
            end
        end
    end

    // Requester that follows the current winner.
    always_comb after_idx = IW'(fxp_pkg::wrap_inc(int'(gnt_idx), N));

    // Advance the pointer past each granted requester.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (gnt_vld) ptr_q <= after_idx;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R6
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R6
    AST_RR_NEXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |=> (!req[$past(after_idx)] || gnt[$past(after_idx)])); // R6
endmodule

// File: rtl/fxp_thread_sel.sv
// Per-core issue selector: fixed priority (context 0 highest) over ready,
// non-stalled contexts; holds a context refused by the complex-unit arbiter;
// owns the core's simple-unit pipeline and the stall bits.
// Assumes: a held context keeps its operation presented until issued.
module fxp_thread_sel #(
    parameter  int NT   = 4,
    parameter  int SLAT = 4,
    localparam int TW   = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] want,
    input  logic [NT-1:0] is_cplx,
    input  logic          cx_gnt,
    input  logic          cx_done,
    input  logic [TW-1:0] cx_done_tid,
    output logic          iss_vld,
    output logic [TW-1:0] iss_tid,
    output logic          iss_cplx,
    output logic          cx_req,
    output logic          sp_wb_vld,
    output logic [TW-1:0] sp_wb_tid,
    output logic [NT-1:0] stall_o
);
    logic [NT-1:0] stall_q, elig, set_mask, clr_mask;
    logic          held_q;
    logic [TW-1:0] held_tid_q;
    logic          sel_vld, sel_cplx;
    logic [TW-1:0] sel_tid;

    // Contexts allowed to compete this cycle.
    always_comb elig = want & ~stall_q;

    // Priority encode (lowest index wins); a held context overrides.
    always_comb begin
        sel_vld = 1'b0;
        sel_tid = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                sel_vld = 1'b1;
                sel_tid = TW'(i);
            end
        end
        sel_cplx = sel_vld & is_cplx[sel_tid];
        if (held_q) begin
            sel_vld  = 1'b1;
            sel_tid  = held_tid_q;
            sel_cplx = 1'b1;
        end
    end

    // Issue goes out unless a complex request is refused.
    always_comb begin
        cx_req   = sel_vld & sel_cplx;
        iss_vld  = sel_vld & (~sel_cplx | cx_gnt);
        iss_tid  = sel_tid;
        iss_cplx = iss_vld & sel_cplx;
    end

    fxp_lat_pipe #(.LAT(SLAT), .TAGW(TW)) u_simple (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (iss_vld & ~sel_cplx),
        .in_tag  (sel_tid),
        .out_vld (sp_wb_vld),
        .out_tag (sp_wb_tid)
    );

    // Stall bits to set on issue and to clear on either writeback.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (iss_vld)   set_mask[sel_tid]     = 1'b1;
        if (sp_wb_vld) clr_mask[sp_wb_tid]   = 1'b1;
        if (cx_done)   clr_mask[cx_done_tid] = 1'b1;
    end

    // Stall bits and the hold state for a refused complex request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q    <= '0;
            held_q     <= 1'b0;
            held_tid_q <= '0;
        end else begin
            stall_q    <= (stall_q & ~clr_mask) | set_mask;
            held_q     <= cx_req & ~cx_gnt;
            held_tid_q <= sel_tid;
        end
    end

    assign stall_o = stall_q;

    AST_NO_STALLED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> !stall_q[iss_tid]); // R3
    AST_STALL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> stall_q[$past(iss_tid)]); // R3
    AST_SIMPLE_WB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wb_vld |-> stall_q[sp_wb_tid]); // R4
    AST_CPLX_WB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        cx_done |-> stall_q[cx_done_tid]); // R5
    AST_HOLD_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cx_req && !cx_gnt) |=> (cx_req && iss_tid == $past(iss_tid))); // R7
    AST_REFUSED_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cx_req && !cx_gnt) |-> !iss_vld); // R7
endmodule

// File: rtl/fxp_issue_cluster.sv
// Cluster top: one issue selector per core, a round-robin arbiter and one
// tagged complex-unit pipeline shared by all cores.
// Assumes: want/cplx are stable for the whole cycle they are sampled in.
module fxp_issue_cluster #(
    parameter  int NUM_CORES   = fxp_pkg::DEF_CORES,
    parameter  int NUM_THREADS = fxp_pkg::DEF_THREADS,
    parameter  int SIMPLE_LAT  = fxp_pkg::DEF_SIMPLE_LAT,
    parameter  int CPLX_LAT    = fxp_pkg::DEF_CPLX_LAT,
    localparam int TW          = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CW          = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int NCT         = NUM_CORES * NUM_THREADS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCT-1:0]          want,
    input  logic [NCT-1:0]          cplx,
    output logic [NUM_CORES-1:0]    iss_vld,
    output logic [NUM_CORES*TW-1:0] iss_tid,
    output logic [NUM_CORES-1:0]    iss_cplx,
    output logic                    cx_gnt_vld,
    output logic [CW-1:0]           cx_gnt_core,
    output logic [NUM_CORES-1:0]    sp_wb_vld,
    output logic [NUM_CORES*TW-1:0] sp_wb_tid,
    output logic                    cx_wb_vld,
    output logic [CW-1:0]           cx_wb_core,
    output logic [TW-1:0]           cx_wb_tid,
    output logic [NCT-1:0]          stall_o
);
    logic [NUM_CORES-1:0] cx_req, cx_gnt;
    logic [TW-1:0]        gnt_tid;
    logic [CW+TW-1:0]     cx_out_tag;

    fxp_rr_arb #(.N(NUM_CORES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cx_req),
        .gnt     (cx_gnt),
        .gnt_vld (cx_gnt_vld),
        .gnt_idx (cx_gnt_core)
    );

    // Context tag of the core that won the complex unit.
    always_comb gnt_tid = iss_tid[int'(cx_gnt_core)*TW +: TW];

    fxp_lat_pipe #(.LAT(CPLX_LAT), .TAGW(CW + TW)) u_cplx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (cx_gnt_vld),
        .in_tag  ({cx_gnt_core, gnt_tid}),
        .out_vld (cx_wb_vld),
        .out_tag (cx_out_tag)
    );

    assign cx_wb_core = cx_out_tag[CW+TW-1:TW];
    assign cx_wb_tid  = cx_out_tag[TW-1:0];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        fxp_thread_sel #(.NT(NUM_THREADS), .SLAT(SIMPLE_LAT)) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .want        (want[c*NUM_THREADS +: NUM_THREADS]),
            .is_cplx     (cplx[c*NUM_THREADS +: NUM_THREADS]),
            .cx_gnt      (cx_gnt[c]),
            .cx_done     (cx_wb_vld && (int'(cx_wb_core) == c)),
            .cx_done_tid (cx_wb_tid),
            .iss_vld     (iss_vld[c]),
            .iss_tid     (iss_tid[c*TW +: TW]),
            .iss_cplx    (iss_cplx[c]),
            .cx_req      (cx_req[c]),
            .sp_wb_vld   (sp_wb_vld[c]),
            .sp_wb_tid   (sp_wb_tid[c*TW +: TW]),
            .stall_o     (stall_o[c*NUM_THREADS +: NUM_THREADS])
        );
    end

    AST_GRANT_IS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iss_cplx) == (cx_gnt_vld ? 1 : 0)); // R9
endmodule

// File: tb/fxp_issue_cluster_tb.sv
// Bench: behavioural per-context countdown model compared on every cycle.
module fxp_issue_cluster_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 6, NT = 4, TW = 2, CW = 3;
    localparam int SLAT = 4, XLAT = 20;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NC*NT-1:0] want = '0, cplx = '0;
    logic [NC-1:0]    iss_vld, iss_cplx, sp_wb_vld;
    logic [NC*TW-1:0] iss_tid, sp_wb_tid;
    logic             cx_gnt_vld, cx_wb_vld;
    logic [CW-1:0]    cx_gnt_core, cx_wb_core;
    logic [TW-1:0]    cx_wb_tid;
    logic [NC*NT-1:0] stall_o;

    fxp_issue_cluster dut_i (
        .clk(clk), .rst_n(rst_n), .want(want), .cplx(cplx),
        .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_cplx(iss_cplx),
        .cx_gnt_vld(cx_gnt_vld), .cx_gnt_core(cx_gnt_core),
        .sp_wb_vld(sp_wb_vld), .sp_wb_tid(sp_wb_tid),
        .cx_wb_vld(cx_wb_vld), .cx_wb_core(cx_wb_core), .cx_wb_tid(cx_wb_tid),
        .stall_o(stall_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // Model state: remaining busy cycles per context, its unit, hold, pointer.
    int m_cnt  [NC][NT];
    bit m_kind [NC][NT];
    bit m_held [NC];
    int m_held_t [NC];
    int m_ptr;
    int m_hold_events = 0;
    // Observations for directed checks.
    int obs_iss0 = 0;
    int grant_log [$];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            m_held[c] = 0; m_held_t[c] = 0;
            for (int t = 0; t < NT; t++) begin m_cnt[c][t] = 0; m_kind[c][t] = 0; end
        end
        m_ptr = 0;
    endtask

    // Predict this cycle's outputs, compare, then advance the model.
    task automatic compare_and_step();
        int  esel [NC];
        bit  evld [NC], ecx [NC], ereq [NC], eiss [NC];
        int  g = -1;
        int  k, ewt, xc, xt;
        bit  ew, xv;
        for (int c = 0; c < NC; c++) begin
            evld[c] = 0; esel[c] = 0; ecx[c] = 0;
            if (m_held[c]) begin
                evld[c] = 1; esel[c] = m_held_t[c]; ecx[c] = 1;
            end else begin
                for (int t = NT - 1; t >= 0; t--)
                    if (want[c*NT+t] && m_cnt[c][t] == 0) begin evld[c] = 1; esel[c] = t; end
                if (evld[c]) ecx[c] = cplx[c*NT+esel[c]];
            end
            ereq[c] = evld[c] && ecx[c];
        end
        for (int off = 0; off < NC; off++) begin
            k = (m_ptr + off) % NC;
            if (g < 0 && ereq[k]) g = k;
        end
        for (int c = 0; c < NC; c++) begin
            eiss[c] = evld[c] && (!ecx[c] || g == c);
            check(m_held[c] ? "R7" : "R2", $sformatf("core%0d issue valid", c), int'(iss_vld[c]), int'(eiss[c]));
            if (eiss[c] && iss_vld[c]) begin
                check(m_held[c] ? "R7" : "R2", $sformatf("core%0d issue tid", c), int'(iss_tid[c*TW +: TW]), esel[c]);
                check("R2", $sformatf("core%0d issue unit", c), int'(iss_cplx[c]), int'(ecx[c]));
            end
            ew = 0; ewt = 0;
            for (int t = 0; t < NT; t++)
                if (m_cnt[c][t] == 1 && !m_kind[c][t]) begin ew = 1; ewt = t; end
            check("R4", $sformatf("core%0d simple wb valid", c), int'(sp_wb_vld[c]), int'(ew));
            if (ew && sp_wb_vld[c]) check("R4", $sformatf("core%0d simple wb tid", c), int'(sp_wb_tid[c*TW +: TW]), ewt);
            for (int t = 0; t < NT; t++)
                check("R3", $sformatf("stall c%0d t%0d", c, t), int'(stall_o[c*NT+t]), int'(m_cnt[c][t] != 0));
        end
        check("R6", "grant valid", int'(cx_gnt_vld), int'(g >= 0));
        if (g >= 0 && cx_gnt_vld) check("R6", "grant core", int'(cx_gnt_core), g);
        xv = 0; xc = 0; xt = 0;
        for (int c = 0; c < NC; c++)
            for (int t = 0; t < NT; t++)
                if (m_cnt[c][t] == 1 && m_kind[c][t]) begin xv = 1; xc = c; xt = t; end
        check("R5", "complex wb valid", int'(cx_wb_vld), int'(xv));
        if (xv && cx_wb_vld) begin
            check("R5", "complex wb core", int'(cx_wb_core), xc);
            check("R5", "complex wb tid", int'(cx_wb_tid), xt);
        end
        if (iss_vld[0]) obs_iss0++;
        if (cx_gnt_vld) grant_log.push_back(int'(cx_gnt_core));
        // Advance model to the state after the coming edge.
        for (int c = 0; c < NC; c++)
            for (int t = 0; t < NT; t++)
                if (m_cnt[c][t] != 0) m_cnt[c][t]--;
        for (int c = 0; c < NC; c++) begin
            if (eiss[c]) begin
                m_cnt[c][esel[c]]  = ecx[c] ? XLAT : SLAT;
                m_kind[c][esel[c]] = ecx[c];
            end
            m_held[c]   = ereq[c] && (g != c);
            m_held_t[c] = esel[c];
            if (m_held[c]) m_hold_events++;
        end
        if (g >= 0) m_ptr = (g + 1) % NC;
    endtask

    // Drive one cycle of stimulus at the falling edge, then check.
    task automatic cycle(input logic [NC*NT-1:0] w, input logic [NC*NT-1:0] x);
        logic [NC*NT-1:0] wv, xvv;
        wv = w; xvv = x;
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            if (m_held[c]) begin wv[c*NT+m_held_t[c]] = 1'b1; xvv[c*NT+m_held_t[c]] = 1'b1; end
        want = wv; cplx = xvv;
        #1;
        compare_and_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle('0, '0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs and clear stall bits under reset
        check("R1", "reset issue", int'(iss_vld), 0);
        check("R1", "reset stall", int'(stall_o != '0), 0);
        check("R1", "reset simple wb", int'(sp_wb_vld), 0);
        check("R1", "reset complex wb", int'(cx_wb_vld), 0);
        rst_n = 1'b1;

        // Phase A, R8: core 0, four ready simple contexts back to back
        obs_iss0 = 0;
        for (int i = 0; i < 4; i++) cycle({{(NC-1)*NT{1'b0}}, 4'hF}, '0);
        check("R8", "simple issues in 4 consecutive cycles", obs_iss0, 4);
        for (int i = 0; i < 8; i++) cycle({{(NC-1)*NT{1'b0}}, 4'hF}, '0);
        idle(8);

        // Phase B, R9 and R1: all cores request complex on context 0
        grant_log.delete();
        for (int i = 0; i < 6; i++) cycle({NC{4'h1}}, {NC{4'h1}});
        check("R9", "grants in 6 consecutive cycles", grant_log.size(), 6);
        if (grant_log.size() > 0) check("R1", "first contention winner", grant_log[0], 0);
        for (int i = 0; i < 6 && i < grant_log.size(); i++)
            check("R6", $sformatf("rotation slot %0d", i), grant_log[i], i);
        idle(24);

        // Phase C, R7: two cores contend, then a higher context becomes ready
        m_hold_events = 0;
        cycle({{3{4'h0}}, 4'h4, 4'h4, 4'h0}, {{3{4'h0}}, 4'h4, 4'h4, 4'h0});
        cycle({{3{4'h0}}, 4'h5, 4'h5, 4'h0}, {{3{4'h0}}, 4'h4, 4'h4, 4'h0});
        check("R7", "hold episode observed", int'(m_hold_events > 0), 1);
        for (int i = 0; i < 6; i++) cycle({{3{4'h0}}, 4'h5, 4'h5, 4'h0}, {{3{4'h0}}, 4'h4, 4'h4, 4'h0});
        idle(24);

        // Phase D: random mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic [NC*NT-1:0] w, x;
            for (int b = 0; b < NC*NT; b++) begin
                w[b] = ($urandom % 100) < 45;
                x[b] = ($urandom % 100) < 30;
            end
            cycle(w, x);
        end
        idle(25);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule